// File: doc/BRIEF.md
# Two-Mode Standby Clock Controller

This block puts a small processor core into one of two low-power standby states and brings it back out. The CPU asks for standby with a one-cycle pulse on `halt_req` or `stop_req`. In the light state, HALT, only the CPU clock enable drops. The main oscillator and the peripheral clocks keep running, so an interrupt resumes execution on the next cycle. In the deep state, STOP, the oscillator enable drops and every clock enable is gated off.

An unmasked interrupt request, `irq_pend`, wakes the block from either state. Leaving STOP passes through a settling phase, WAIT. During WAIT the oscillator runs again, but the clocks stay gated while a down-counter, loaded from `settle_cnt` at the moment of release, counts to zero. STOP is refused while the system runs from the subsystem clock. A refused STOP raises a sticky error flag, which software clears with `err_clr`.

The block asserts no reset towards any register or output latch it controls. It only gates clocks, so held state survives standby. All pins are plain control and status signals, and no data streams through the block, so it has no valid/ready handshake.

Top module: `stby_clk_ctrl`

## Requirements
- R1: After reset the status `mode_stat` reads 0 (run), `osc_en`, `cpu_clk_en` and `per_clk_en` are all 1, and `stop_err` is 0.
- R2: A `halt_req` pulse in run, with no interrupt pending, gives on the next cycle `mode_stat`=1 (halt), `cpu_clk_en`=0, `osc_en`=1 and `per_clk_en`=1. This holds with either value of `sub_clk_sel`.
- R3: A `stop_req` pulse in run, with `sub_clk_sel`=0 and no interrupt pending, gives on the next cycle `mode_stat`=2 (stop) with `osc_en`, `cpu_clk_en` and `per_clk_en` all 0.
- R4: `irq_pend` high in halt returns the block to run on the next cycle with all enables at 1. There is no settling wait.
- R5: `irq_pend` high in stop moves the block to `mode_stat`=3 (wait) and captures `settle_cnt` as N. In wait, `osc_en`=1 and both clock enables are 0. The block stays in wait for exactly N+1 cycles and then enters run with all enables at 1.
- R6: A `stop_req` with `sub_clk_sel`=1 is refused. The mode stays run and the enables are unchanged. If `halt_req` arrives in the same cycle, HALT is still accepted.
- R7: A refused STOP sets `stop_err`. The flag stays at 1 until an `err_clr` pulse clears it. A new refusal in the same cycle as `err_clr` wins, and the flag stays 1.
- R8: A `halt_req` or `stop_req` that arrives in run while `irq_pend` is high is cancelled, and the block stays in run.
- R9: `halt_req` and `stop_req` are ignored in halt, stop and wait. Only `irq_pend` and the settling counter move the block out of those states.
- R10: When both requests arrive together and STOP is accepted, STOP takes priority over HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| halt_req | input | 1 | One-cycle request for light standby |
| stop_req | input | 1 | One-cycle request for deep standby |
| irq_pend | input | 1 | Unmasked interrupt request level |
| sub_clk_sel | input | 1 | 1 when the subsystem clock drives the system |
| settle_cnt | input | CNT_W | Oscillator settling count, captured on release from stop |
| err_clr | input | 1 | Software write pulse that clears `stop_err` |
| osc_en | output | 1 | Main oscillator enable, registered |
| cpu_clk_en | output | 1 | CPU clock gate enable, registered |
| per_clk_en | output | 1 | Peripheral clock gate enable, registered |
| mode_stat | output | 2 | 0 run, 1 halt, 2 stop, 3 wait |
| stop_err | output | 1 | Sticky flag for a refused STOP |

## Verification
The bench goes after the settling window. It uses settle counts of zero and of several cycles. A counter that is off by one would release the clocks a cycle early or late, or hang in wait when the count is zero. The bench also drives STOP while the subsystem clock is selected, alone and together with HALT. A design that skipped that check would kill the oscillator, and one that dropped the simultaneous HALT would fail to enter halt. Requests arriving with an interrupt already pending, or arriving during standby, are fired repeatedly. A design that honoured either would show a non-run mode, or would leave standby early. The bench also collides an error clear with a new refusal, to catch a flag where the clear wins.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STOP = 2'd2,
    ST_WAIT = 2'd3
  } stby_state_e;
endpackage

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= load_val;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);

  // R5
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/stby_err_flag.sv
module stby_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt_req,
  input  logic        stop_req,
  input  logic        irq_pend,
  input  logic        sub_clk_sel,
  input  logic        cnt_zero,
  output logic        cnt_load,
  output logic        cnt_dec,
  output logic        stop_refused,
  output logic        osc_en,
  output logic        cpu_clk_en,
  output logic        per_clk_en,
  output stby_state_e state
);
  stby_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (!irq_pend) begin
          if (stop_req && !sub_clk_sel) st_d = ST_STOP;
          else if (halt_req)            st_d = ST_HALT;
        end
      end
      ST_HALT: if (irq_pend) st_d = ST_RUN;
      ST_STOP: if (irq_pend) st_d = ST_WAIT;
      ST_WAIT: if (cnt_zero) st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  assign cnt_load     = (st_q == ST_STOP) && irq_pend;
  assign cnt_dec      = (st_q == ST_WAIT);
  assign stop_refused = (st_q == ST_RUN) && stop_req && sub_clk_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      osc_en     <= 1'b1;
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
    end else begin
      st_q       <= st_d;
      osc_en     <= (st_d != ST_STOP);
      cpu_clk_en <= (st_d == ST_RUN);
      per_clk_en <= (st_d == ST_RUN) || (st_d == ST_HALT);
    end
  end

  assign state = st_q;

  // R2
  halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT) |-> (!cpu_clk_en && osc_en && per_clk_en));

  // R3
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP) |-> (!osc_en && !cpu_clk_en && !per_clk_en));

  // R4
  halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HALT && irq_pend) |=> (st_q == ST_RUN && cpu_clk_en));

  // R5
  wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (osc_en && !cpu_clk_en && !per_clk_en));

  // R6
  stop_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && stop_req && sub_clk_sel) |=> (st_q != ST_STOP));

  // R8
  req_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && irq_pend) |=> (st_q == ST_RUN));
endmodule

// File: rtl/stby_clk_ctrl.sv
module stby_clk_ctrl
  import stby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             stop_req,
  input  logic             irq_pend,
  input  logic             sub_clk_sel,
  input  logic [CNT_W-1:0] settle_cnt,
  input  logic             err_clr,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic [1:0]       mode_stat,
  output logic             stop_err
);
  logic        cnt_load, cnt_dec, cnt_zero, stop_refused;
  stby_state_e state;

  stby_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req),
    .stop_req     (stop_req),
    .irq_pend     (irq_pend),
    .sub_clk_sel  (sub_clk_sel),
    .cnt_zero     (cnt_zero),
    .cnt_load     (cnt_load),
    .cnt_dec      (cnt_dec),
    .stop_refused (stop_refused),
    .osc_en       (osc_en),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .state        (state)
  );

  stby_settle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (settle_cnt),
    .dec      (cnt_dec),
    .cnt_zero (cnt_zero)
  );

  stby_err_flag u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (stop_refused),
    .clr   (err_clr),
    .flag  (stop_err)
  );

  assign mode_stat = state;
endmodule

// File: tb/stby_clk_ctrl_tb.sv
module stby_clk_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, stop_req = 0, irq_pend = 0, sub_clk_sel = 0, err_clr = 0;
  logic [CNT_W-1:0] settle_cnt = '0;
  logic osc_en, cpu_clk_en, per_clk_en, stop_err;
  logic [1:0] mode_stat;

  int n_tests = 0;
  int n_fail  = 0;

  logic [1:0]       m_st;
  logic [CNT_W-1:0] m_cnt;
  logic             m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_clk_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .irq_pend(irq_pend), .sub_clk_sel(sub_clk_sel), .settle_cnt(settle_cnt),
    .err_clr(err_clr), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .mode_stat(mode_stat), .stop_err(stop_err)
  );

  function automatic logic [4:0] expect_pins(input logic [1:0] st, input logic er);
    logic o, c, p;
    o = (st != 2'd2);
    c = (st == 2'd0);
    p = (st == 2'd0) || (st == 2'd1);
    return {st, o, c, p} ^ 5'b0 | {4'b0, 1'b0} ^ ({4'b0, er} & 5'b0);
  endfunction

  task automatic check(input string tag, input logic [1:0] exp_st, input logic exp_err);
    logic [4:0] e, a;
    e = expect_pins(exp_st, exp_err);
    a = {mode_stat, osc_en, cpu_clk_en, per_clk_en};
    n_tests++;
    if (a !== e || stop_err !== exp_err) begin
      n_fail++;
      $display("FAIL %s: got mode/osc/cpu/per=%b err=%b, expected %b err=%b",
               tag, a, stop_err, e, exp_err);
    end
  endtask

  task automatic model_step();
    logic set;
    set = 1'b0;
    case (m_st)
      2'd0: begin
        if (stop_req && sub_clk_sel) set = 1'b1;
        if (!irq_pend) begin
          if (stop_req && !sub_clk_sel) m_st = 2'd2;
          else if (halt_req)            m_st = 2'd1;
        end
      end
      2'd1: if (irq_pend) m_st = 2'd0;
      2'd2: if (irq_pend) begin m_st = 2'd3; m_cnt = settle_cnt; end
      default: if (m_cnt == 0) m_st = 2'd0; else m_cnt = m_cnt - 1'b1;
    endcase
    if (set) m_err = 1'b1;
    else if (err_clr) m_err = 1'b0;
  endtask

  task automatic cyc(input string tag, input logic h, input logic s, input logic i,
                     input logic sub, input logic [CNT_W-1:0] n, input logic clr);
    halt_req = h; stop_req = s; irq_pend = i; sub_clk_sel = sub;
    settle_cnt = n; err_clr = clr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag, m_st, m_err);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    m_st = 2'd0; m_cnt = '0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 2'd0, 1'b0);

    // R2 halt, then R4 wake with no wait
    cyc("R2 halt entry", 1, 0, 0, 0, 0, 0);
    check("R2 halt state", 2'd1, 1'b0);
    cyc("R9 req in halt", 0, 1, 0, 0, 0, 0);
    cyc("R4 halt wake", 0, 0, 1, 0, 0, 0);
    check("R4 run now", 2'd0, 1'b0);

    // R3 stop, R5 wait of N+1 cycles, N=5
    cyc("R3 stop entry", 0, 1, 0, 0, 0, 0);
    check("R3 stop state", 2'd2, 1'b0);
    cyc("R9 halt in stop", 1, 0, 0, 0, 0, 0);
    cyc("R5 release", 0, 0, 1, 0, 8'd5, 0);
    for (int k = 0; k < 5; k++) begin
      cyc("R5 settling", 1, 1, 0, 0, 8'd9, 0);
      check("R5 still wait", 2'd3, 1'b0);
    end
    cyc("R5 end wait", 0, 0, 0, 0, 0, 0);
    check("R5 back to run", 2'd0, 1'b0);

    // R5 zero count
    cyc("R10 both req", 1, 1, 0, 0, 0, 0);
    check("R10 stop wins", 2'd2, 1'b0);
    cyc("R5 release n0", 0, 0, 1, 0, 8'd0, 0);
    check("R5 wait n0", 2'd3, 1'b0);
    cyc("R5 run n0", 0, 0, 0, 0, 0, 0);
    check("R5 run after n0", 2'd0, 1'b0);

    // R6 / R7 refusal
    cyc("R6 refuse", 0, 1, 0, 1, 0, 0);
    check("R6 stays run", 2'd0, 1'b1);
    cyc("R7 sticky", 0, 0, 0, 0, 0, 0);
    check("R7 still set", 2'd0, 1'b1);
    cyc("R7 set wins", 0, 1, 0, 1, 0, 1);
    check("R7 set over clr", 2'd0, 1'b1);
    cyc("R7 clear", 0, 0, 0, 0, 0, 1);
    check("R7 cleared", 2'd0, 1'b0);
    cyc("R6 halt on sub", 1, 1, 0, 1, 0, 0);
    check("R6 halt accepted", 2'd1, 1'b1);
    cyc("R4 wake", 0, 0, 1, 1, 0, 1);

    // R8 cancel
    cyc("R8 halt cancel", 1, 0, 1, 0, 0, 0);
    check("R8 run", 2'd0, 1'b0);
    cyc("R8 stop cancel", 0, 1, 1, 0, 0, 0);
    check("R8 run again", 2'd0, 1'b0);

    // random mix against model
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      cyc("R9 random", r[0] & r[1], r[2] & r[3], ($urandom % 6) == 0,
          ($urandom % 4) == 0, CNT_W'($urandom % 8), ($urandom % 10) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule